// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the controller of a multicycle processor datapath. It is a Moore state machine: every datapath control output is a pure function of the current state, and the opcode and the arithmetic overflow flag only steer which state comes next. An instruction passes through fetch, decode and one to three instruction-specific steps, so it occupies three, four or five clock cycles. After that the machine returns to fetch.

Two exception paths are built in. An opcode outside the supported set is trapped right after decode. An overflow reported while an R-type result is being written is trapped right after that write. Each trap spends one cycle recording a cause code and the faulting instruction's address, which is the PC minus 4, computed by the ALU. In the same cycle it loads the PC from the exception-vector input of the PC multiplexer. It then resumes fetching.

Top module: `mc_ctrl_seq`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), and in the cycle after it is released, the outputs show the fetch pattern. Reset asserted in the middle of an instruction abandons that instruction at once.
- R2: Fetch asserts pc_wr, mem_rd and ir_wr, with addr_sel=0, alu_a_sel=0, alu_b_sel=01, alu_op=00 and pc_src=00. It is always followed by decode, whatever the opcode.
- R3: Decode drives alu_b_sel=11 with alu_a_sel=0 and alu_op=00. It branches on the opcode: 0x23 or 0x2B go to address compute, 0x00 goes to execute, 0x04 goes to branch, 0x02 goes to jump, and any other value goes to the illegal-opcode trap.
- R4: A load (0x23) runs fetch, decode, address compute, read and write-back: five cycles. Address compute drives alu_a_sel=1 and alu_b_sel=10. Read drives mem_rd with addr_sel=1. Write-back drives rf_wr with wb_sel_mem=1 and rf_dst_sel=0.
- R5: A store (0x2B) runs fetch, decode, address compute and a write cycle: four cycles. The write cycle drives mem_wr with addr_sel=1.
- R6: An R-type (0x00) runs fetch, decode, execute and commit: four cycles. Execute drives alu_a_sel=1, alu_b_sel=00 and alu_op=10. Commit drives rf_wr with rf_dst_sel=1 and wb_sel_mem=0. Without overflow, commit returns to fetch.
- R7: When ovf is high during commit, the next cycle is the overflow trap. It drives cause_wr, epc_wr and pc_wr with cause_code=1, alu_b_sel=01, alu_op=01 and pc_src=11. It then returns to fetch.
- R8: Beq (0x04) takes three cycles. Its third cycle drives pc_wr_cond with pc_src=01, alu_op=01 and alu_a_sel=1. Jump (0x02) takes three cycles. Its third cycle drives pc_wr with pc_src=10.
- R9: An illegal opcode produces one trap cycle after decode. That cycle matches the overflow trap except that cause_code=0, and it then returns to fetch.
- R10: In every state, each enable and each select that the state does not name is 0.
- R11: The opcode has no effect outside decode and address compute, and ovf has no effect outside commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | OP_W (6) | Opcode field of the instruction register |
| ovf | input | 1 | ALU overflow flag |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by ALU zero |
| addr_sel | output | 1 | Memory address: 0 = PC, 1 = ALU result register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| wb_sel_mem | output | 1 | Register write data: 1 = memory data register, 0 = ALU result |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target, 11 exception vector |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU A input: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B input: 00 register B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| rf_wr | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Destination register: 1 = rd field, 0 = rt field |
| cause_code | output | 1 | Exception cause select: 0 illegal opcode, 1 overflow |
| cause_wr | output | 1 | Cause register write |
| epc_wr | output | 1 | Exception PC register write |

## Verification
The overflow trap is the hardest case to reach from the ports. ovf is honoured only in the single commit cycle of an R-type instruction, so the stimulus raises it exactly at that step. In other runs it holds ovf high through every other state and shows that no trap follows. The same runs drive an unsupported opcode in every state except decode and address compute, which shows that the opcode is read only in those two states. A reset asserted midway through a load shows that an instruction can be abandoned and fetch restarts cleanly.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

   typedef enum logic [3:0] {
      ST_FETCH  = 4'd0,
      ST_DECODE = 4'd1,
      ST_ADDR   = 4'd2,
      ST_MEMRD  = 4'd3,
      ST_WBACK  = 4'd4,
      ST_MEMWR  = 4'd5,
      ST_EXEC   = 4'd6,
      ST_RCOMM  = 4'd7,
      ST_BRANCH = 4'd8,
      ST_JUMP   = 4'd9,
      ST_ILLOP  = 4'd10,
      ST_OVFL   = 4'd11
   } mc_state_e;

   typedef struct packed {
      logic       pc_wr;
      logic       pc_wr_cond;
      logic       addr_sel;
      logic       mem_rd;
      logic       mem_wr;
      logic       ir_wr;
      logic       wb_sel_mem;
      logic [1:0] pc_src;
      logic [1:0] alu_op;
      logic       alu_a_sel;
      logic [1:0] alu_b_sel;
      logic       rf_wr;
      logic       rf_dst_sel;
      logic       cause_code;
      logic       cause_wr;
      logic       epc_wr;
   } mc_ctrl_t;

   localparam logic [5:0] OPC_RTYPE_DEF = 6'h00;
   localparam logic [5:0] OPC_LOAD_DEF  = 6'h23;
   localparam logic [5:0] OPC_STORE_DEF = 6'h2B;
   localparam logic [5:0] OPC_BEQ_DEF   = 6'h04;
   localparam logic [5:0] OPC_JUMP_DEF  = 6'h02;

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
   import mc_ctrl_pkg::*;
#(
   parameter int              OP_W      = 6,
   parameter logic [OP_W-1:0] OPC_RTYPE = OP_W'(OPC_RTYPE_DEF),
   parameter logic [OP_W-1:0] OPC_LOAD  = OP_W'(OPC_LOAD_DEF),
   parameter logic [OP_W-1:0] OPC_STORE = OP_W'(OPC_STORE_DEF),
   parameter logic [OP_W-1:0] OPC_BEQ   = OP_W'(OPC_BEQ_DEF),
   parameter logic [OP_W-1:0] OPC_JUMP  = OP_W'(OPC_JUMP_DEF)
) (
   input  mc_state_e       cur,
   input  logic [OP_W-1:0] opcode,
   input  logic            ovf,
   output mc_state_e       nxt
);

   logic is_mem;
   assign is_mem = (opcode == OPC_LOAD) || (opcode == OPC_STORE);

   always_comb begin
      nxt = ST_FETCH;
      unique case (cur)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: begin
            if (is_mem)                    nxt = ST_ADDR;
            else if (opcode == OPC_RTYPE)  nxt = ST_EXEC;
            else if (opcode == OPC_BEQ)    nxt = ST_BRANCH;
            else if (opcode == OPC_JUMP)   nxt = ST_JUMP;
            else                           nxt = ST_ILLOP;
         end
         ST_ADDR:   nxt = (opcode == OPC_LOAD) ? ST_MEMRD : ST_MEMWR;
         ST_MEMRD:  nxt = ST_WBACK;
         ST_EXEC:   nxt = ST_RCOMM;
         ST_RCOMM:  nxt = ovf ? ST_OVFL : ST_FETCH;
         default:   nxt = ST_FETCH;
      endcase
   end

endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
   import mc_ctrl_pkg::*;
(
   input  mc_state_e cur,
   output mc_ctrl_t  ctl
);

   always_comb begin
      ctl = '0;
      unique case (cur)
         ST_FETCH: begin
            ctl.mem_rd    = 1'b1;
            ctl.ir_wr     = 1'b1;
            ctl.alu_b_sel = 2'b01;
            ctl.pc_wr     = 1'b1;
         end
         ST_DECODE: ctl.alu_b_sel = 2'b11;
         ST_ADDR: begin
            ctl.alu_a_sel = 1'b1;
            ctl.alu_b_sel = 2'b10;
         end
         ST_MEMRD: begin
            ctl.mem_rd   = 1'b1;
            ctl.addr_sel = 1'b1;
         end
         ST_WBACK: begin
            ctl.rf_wr      = 1'b1;
            ctl.wb_sel_mem = 1'b1;
         end
         ST_MEMWR: begin
            ctl.mem_wr   = 1'b1;
            ctl.addr_sel = 1'b1;
         end
         ST_EXEC: begin
            ctl.alu_a_sel = 1'b1;
            ctl.alu_op    = 2'b10;
         end
         ST_RCOMM: begin
            ctl.rf_wr      = 1'b1;
            ctl.rf_dst_sel = 1'b1;
         end
         ST_BRANCH: begin
            ctl.alu_a_sel  = 1'b1;
            ctl.alu_op     = 2'b01;
            ctl.pc_wr_cond = 1'b1;
            ctl.pc_src     = 2'b01;
         end
         ST_JUMP: begin
            ctl.pc_wr  = 1'b1;
            ctl.pc_src = 2'b10;
         end
         ST_ILLOP, ST_OVFL: begin
            ctl.cause_wr   = 1'b1;
            ctl.epc_wr     = 1'b1;
            ctl.pc_wr      = 1'b1;
            ctl.alu_b_sel  = 2'b01;
            ctl.alu_op     = 2'b01;
            ctl.pc_src     = 2'b11;
            ctl.cause_code = (cur == ST_OVFL);
         end
         default: ctl = '0;
      endcase
   end

endmodule

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
   import mc_ctrl_pkg::*;
#(
   parameter int              OP_W      = 6,
   parameter bit              ASYNC_RST = 1'b1,
   parameter logic [OP_W-1:0] OPC_RTYPE = OP_W'(OPC_RTYPE_DEF),
   parameter logic [OP_W-1:0] OPC_LOAD  = OP_W'(OPC_LOAD_DEF),
   parameter logic [OP_W-1:0] OPC_STORE = OP_W'(OPC_STORE_DEF),
   parameter logic [OP_W-1:0] OPC_BEQ   = OP_W'(OPC_BEQ_DEF),
   parameter logic [OP_W-1:0] OPC_JUMP  = OP_W'(OPC_JUMP_DEF)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] opcode,
   input  logic            ovf,
   output logic            pc_wr,
   output logic            pc_wr_cond,
   output logic            addr_sel,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic            ir_wr,
   output logic            wb_sel_mem,
   output logic [1:0]      pc_src,
   output logic [1:0]      alu_op,
   output logic            alu_a_sel,
   output logic [1:0]      alu_b_sel,
   output logic            rf_wr,
   output logic            rf_dst_sel,
   output logic            cause_code,
   output logic            cause_wr,
   output logic            epc_wr
);

   localparam int ST_W = $bits(mc_state_e);

   generate
      if (OP_W < 1)
         $error("mc_ctrl_seq: OP_W must be positive");
      if (ST_W < 4)
         $error("mc_ctrl_seq: state encoding needs at least 4 bits");
      if (OPC_LOAD == OPC_STORE || OPC_LOAD == OPC_RTYPE || OPC_LOAD == OPC_BEQ ||
          OPC_LOAD == OPC_JUMP || OPC_STORE == OPC_RTYPE || OPC_STORE == OPC_BEQ ||
          OPC_STORE == OPC_JUMP || OPC_RTYPE == OPC_BEQ || OPC_RTYPE == OPC_JUMP ||
          OPC_BEQ == OPC_JUMP)
         $error("mc_ctrl_seq: opcode values must be distinct");
   endgenerate

   mc_state_e state_q;
   mc_state_e state_d;
   mc_ctrl_t  ctl;

   mc_ctrl_next #(
      .OP_W     (OP_W),
      .OPC_RTYPE(OPC_RTYPE),
      .OPC_LOAD (OPC_LOAD),
      .OPC_STORE(OPC_STORE),
      .OPC_BEQ  (OPC_BEQ),
      .OPC_JUMP (OPC_JUMP)
   ) u_next (
      .cur   (state_q),
      .opcode(opcode),
      .ovf   (ovf),
      .nxt   (state_d)
   );

   mc_ctrl_out u_out (
      .cur(state_q),
      .ctl(ctl)
   );

   generate
      if (ASYNC_RST) begin : g_arst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) state_q <= ST_FETCH;
            else        state_q <= state_d;
         end
      end else begin : g_srst
         always_ff @(posedge clk) begin
            if (!rst_n) state_q <= ST_FETCH;
            else        state_q <= state_d;
         end
      end
   endgenerate

   assign pc_wr      = ctl.pc_wr;
   assign pc_wr_cond = ctl.pc_wr_cond;
   assign addr_sel   = ctl.addr_sel;
   assign mem_rd     = ctl.mem_rd;
   assign mem_wr     = ctl.mem_wr;
   assign ir_wr      = ctl.ir_wr;
   assign wb_sel_mem = ctl.wb_sel_mem;
   assign pc_src     = ctl.pc_src;
   assign alu_op     = ctl.alu_op;
   assign alu_a_sel  = ctl.alu_a_sel;
   assign alu_b_sel  = ctl.alu_b_sel;
   assign rf_wr      = ctl.rf_wr;
   assign rf_dst_sel = ctl.rf_dst_sel;
   assign cause_code = ctl.cause_code;
   assign cause_wr   = ctl.cause_wr;
   assign epc_wr     = ctl.epc_wr;

endmodule

// File: rtl/mc_ctrl_seq_chk.sv
module mc_ctrl_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ovf,
   input logic       pc_wr,
   input logic       pc_wr_cond,
   input logic       addr_sel,
   input logic       mem_rd,
   input logic       mem_wr,
   input logic       ir_wr,
   input logic       wb_sel_mem,
   input logic [1:0] alu_b_sel,
   input logic       rf_wr,
   input logic       rf_dst_sel,
   input logic       cause_code,
   input logic       epc_wr
);

   // R2: a fetch cycle is always followed by decode
   a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_n)
      ir_wr |=> (alu_b_sel == 2'b11 && !ir_wr && !pc_wr));

   // R4: the load read cycle is followed by write-back from memory data
   a_r4_read_then_wback: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && addr_sel) |=> (rf_wr && wb_sel_mem && !rf_dst_sel));

   // R5: a store write cycle returns to fetch
   a_r5_store_done: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> ir_wr);

   // R6: an R-type commit without overflow returns to fetch
   a_r6_commit_done: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_wr && rf_dst_sel && !ovf) |=> ir_wr);

   // R7: overflow during commit enters the overflow trap
   a_r7_ovf_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_wr && rf_dst_sel && ovf) |=> (epc_wr && cause_code));

   // R8: a branch completes in one cycle and returns to fetch
   a_r8_branch_done: assert property (@(posedge clk) disable iff (!rst_n)
      pc_wr_cond |=> ir_wr);

   // R9: a trap cycle lasts one cycle and resumes fetch
   a_r9_trap_resume: assert property (@(posedge clk) disable iff (!rst_n)
      epc_wr |=> (ir_wr && !epc_wr));

   // R10: memory is never read and written in the same cycle
   a_r10_mem_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

endmodule

bind mc_ctrl_seq mc_ctrl_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ovf       (ovf),
   .pc_wr     (pc_wr),
   .pc_wr_cond(pc_wr_cond),
   .addr_sel  (addr_sel),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .ir_wr     (ir_wr),
   .wb_sel_mem(wb_sel_mem),
   .alu_b_sel (alu_b_sel),
   .rf_wr     (rf_wr),
   .rf_dst_sel(rf_dst_sel),
   .cause_code(cause_code),
   .epc_wr    (epc_wr)
);

// File: tb/mc_ctrl_seq_test.sv
`timescale 1ns/1ps
module mc_ctrl_seq_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] opcode = 6'h00;
   logic       ovf = 1'b0;
   logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel_mem;
   logic [1:0] pc_src, alu_op, alu_b_sel;
   logic       alu_a_sel, rf_wr, rf_dst_sel, cause_code, cause_wr, epc_wr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mc_ctrl_seq uut (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .ovf(ovf),
      .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_sel_mem(wb_sel_mem),
      .pc_src(pc_src), .alu_op(alu_op), .alu_a_sel(alu_a_sel),
      .alu_b_sel(alu_b_sel), .rf_wr(rf_wr), .rf_dst_sel(rf_dst_sel),
      .cause_code(cause_code), .cause_wr(cause_wr), .epc_wr(epc_wr)
   );

   logic [18:0] obs;
   assign obs = {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel_mem,
                 pc_src, alu_op, alu_a_sel, alu_b_sel, rf_wr, rf_dst_sel,
                 cause_code, cause_wr, epc_wr};

   // Step identifiers used by the reference model
   localparam int S_FETCH = 0, S_DEC = 1, S_ADDR = 2, S_RD = 3, S_WB = 4,
                  S_WR = 5, S_EXE = 6, S_COM = 7, S_BR = 8, S_JMP = 9,
                  S_ILL = 10, S_OVF = 11;
   localparam int K_LOAD = 0, K_STORE = 1, K_RTYPE = 2, K_BEQ = 3, K_JUMP = 4,
                  K_ILL = 5;
   localparam logic [5:0] JUNK_OP = 6'h15;

   function automatic logic [18:0] pack(
      input logic pcw, input logic pcc, input logic iord, input logic mrd,
      input logic mwr, input logic irw, input logic m2r, input logic [1:0] psrc,
      input logic [1:0] aop, input logic asa, input logic [1:0] asb,
      input logic rfw, input logic rdst, input logic ic, input logic cw,
      input logic ew);
      return {pcw, pcc, iord, mrd, mwr, irw, m2r, psrc, aop, asa, asb,
              rfw, rdst, ic, cw, ew};
   endfunction

   function automatic logic [18:0] expect_word(input int s);
      case (s)
         S_FETCH: return pack(1,0,0,1,0,1,0,2'd0,2'd0,0,2'd1,0,0,0,0,0);
         S_DEC:   return pack(0,0,0,0,0,0,0,2'd0,2'd0,0,2'd3,0,0,0,0,0);
         S_ADDR:  return pack(0,0,0,0,0,0,0,2'd0,2'd0,1,2'd2,0,0,0,0,0);
         S_RD:    return pack(0,0,1,1,0,0,0,2'd0,2'd0,0,2'd0,0,0,0,0,0);
         S_WB:    return pack(0,0,0,0,0,0,1,2'd0,2'd0,0,2'd0,1,0,0,0,0);
         S_WR:    return pack(0,0,1,0,1,0,0,2'd0,2'd0,0,2'd0,0,0,0,0,0);
         S_EXE:   return pack(0,0,0,0,0,0,0,2'd0,2'd2,1,2'd0,0,0,0,0,0);
         S_COM:   return pack(0,0,0,0,0,0,0,2'd0,2'd0,0,2'd0,1,1,0,0,0);
         S_BR:    return pack(0,1,0,0,0,0,0,2'd1,2'd1,1,2'd0,0,0,0,0,0);
         S_JMP:   return pack(1,0,0,0,0,0,0,2'd2,2'd0,0,2'd0,0,0,0,0,0);
         S_ILL:   return pack(1,0,0,0,0,0,0,2'd3,2'd1,0,2'd1,0,0,0,1,1);
         default: return pack(1,0,0,0,0,0,0,2'd3,2'd1,0,2'd1,0,0,1,1,1);
      endcase
   endfunction

   function automatic string tag_of(input int s);
      case (s)
         S_FETCH:          return "R2 R10";
         S_DEC:            return "R3 R10";
         S_ADDR:           return "R4/R5 R10";
         S_RD, S_WB:       return "R4 R10";
         S_WR:             return "R5 R10";
         S_EXE, S_COM:     return "R6 R10";
         S_BR, S_JMP:      return "R8 R10";
         S_ILL:            return "R9 R10";
         default:          return "R7 R10";
      endcase
   endfunction

   task automatic check(input logic [18:0] exp, input string tag);
      total++;
      if (obs !== exp) begin
         bad++;
         $display("FAIL %s: actual=%05h expected=%05h at %0t", tag, obs, exp, $time);
      end
   endtask

   // Runs one instruction. Caller sits at a negedge with the machine in fetch;
   // on return it sits at the negedge where the next fetch is visible.
   task automatic run_instr(input int kind, input logic [5:0] op,
                            input logic ovf_at_commit, input bit noise);
      int steps[$];
      string pre;
      steps.push_back(S_FETCH);
      steps.push_back(S_DEC);
      case (kind)
         K_LOAD:  begin steps.push_back(S_ADDR); steps.push_back(S_RD); steps.push_back(S_WB); end
         K_STORE: begin steps.push_back(S_ADDR); steps.push_back(S_WR); end
         K_RTYPE: begin
            steps.push_back(S_EXE); steps.push_back(S_COM);
            if (ovf_at_commit) steps.push_back(S_OVF);
         end
         K_BEQ:   steps.push_back(S_BR);
         K_JUMP:  steps.push_back(S_JMP);
         default: steps.push_back(S_ILL);
      endcase
      pre = noise ? "R11 " : "";
      foreach (steps[i]) begin
         check(expect_word(steps[i]), {pre, tag_of(steps[i])});
         if (steps[i] == S_DEC || steps[i] == S_ADDR) opcode = op;
         else opcode = noise ? JUNK_OP : op;
         if (steps[i] == S_COM) ovf = ovf_at_commit;
         else ovf = noise;
         @(negedge clk);
      end
      ovf = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(expect_word(S_FETCH), "R1 reset");
      rst_n = 1'b1;
      check(expect_word(S_FETCH), "R1 release");

      run_instr(K_LOAD,  6'h23, 1'b0, 1'b0);
      run_instr(K_STORE, 6'h2B, 1'b0, 1'b0);
      run_instr(K_RTYPE, 6'h00, 1'b0, 1'b0);
      run_instr(K_RTYPE, 6'h00, 1'b1, 1'b0);
      run_instr(K_BEQ,   6'h04, 1'b0, 1'b0);
      run_instr(K_JUMP,  6'h02, 1'b0, 1'b0);
      run_instr(K_ILL,   6'h3F, 1'b0, 1'b0);
      run_instr(K_ILL,   6'h01, 1'b0, 1'b0);
      run_instr(K_ILL,   6'h22, 1'b0, 1'b0);
      run_instr(K_ILL,   6'h2A, 1'b0, 1'b0);
      run_instr(K_LOAD,  6'h23, 1'b0, 1'b1);
      run_instr(K_STORE, 6'h2B, 1'b0, 1'b1);
      run_instr(K_RTYPE, 6'h00, 1'b0, 1'b1);
      run_instr(K_RTYPE, 6'h00, 1'b1, 1'b1);
      run_instr(K_BEQ,   6'h04, 1'b0, 1'b1);
      run_instr(K_JUMP,  6'h02, 1'b0, 1'b1);

      // R1: reset in the middle of a load abandons it
      check(expect_word(S_FETCH), "R1 R2 pre-abort fetch");
      opcode = 6'h23;
      @(negedge clk);
      check(expect_word(S_DEC), "R1 R3 pre-abort decode");
      @(negedge clk);
      check(expect_word(S_ADDR), "R1 R4 pre-abort address");
      @(negedge clk);
      check(expect_word(S_RD), "R1 R4 pre-abort read");
      #1 rst_n = 1'b0;
      #1 check(expect_word(S_FETCH), "R1 async abort");
      @(negedge clk);
      check(expect_word(S_FETCH), "R1 held in reset");
      rst_n = 1'b1;
      run_instr(K_JUMP, 6'h02, 1'b0, 1'b0);
      run_instr(K_LOAD, 6'h23, 1'b0, 1'b0);
      check(expect_word(S_FETCH), "R2 final fetch");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule